// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block sits on the host side of an SMBus segment and listens, as a slave at a fixed host address, for notification messages that a device sends while it briefly acts as bus master. It does not handle bit timing. A byte-level slave bus engine sits in front of it and reports four kinds of event: start and stop conditions, a received address byte that carries the direction bit, and received data bytes. For every address byte and data byte, the block returns an ACK or NACK decision one cycle later.

A well-formed notification has four parts in this order:

1. A start condition, followed by the host address with the write direction.
2. The notifying device's address, in the byte position where a command byte would normally appear.
3. Two data bytes, low byte first, then high byte.
4. A stop condition.

When such a message completes, the block latches the device address and the 16-bit word and raises a sticky interrupt. The interrupt stays high until software pulses the clear input. The block discards any message that is malformed or cut short and raises no interrupt for it. If a second message completes while the interrupt is still pending, the block sets an overrun flag and keeps the first message's values.

Top module: `smb_notify_rx`

## Requirements
- R1: After reset, `notify_irq`, `notify_ovr`, `resp_valid` and `resp_ack` are 0, and `notify_dev` and `notify_word` are all zeros.
- R2: An address byte uses bits [7:1] for the address and bit 0 for the direction (0 = write, 1 = read). The cycle after an address byte that follows a start, `resp_valid` is 1. `resp_ack` is 1 only when bits [7:1] equal `HOST_ADDR` and bit 0 is 0. Any other address, including the host address with the read direction, is NACKed. Every data byte that follows a NACKed address is also NACKed, and no interrupt results.
- R3: The first payload byte is the device address. Its bits [7:1] appear on `notify_dev` and bit 0 is dropped.
- R4: The second payload byte is the low byte of the word and the third is the high byte, so `notify_word` = {third byte, second byte}.
- R5: A stop that follows the third payload byte raises `notify_irq` in the cycle after the stop, and the captured values are visible on the outputs in that same cycle.
- R6: If a stop or a new start arrives before the stop that completes a message, the partial message is discarded. `notify_irq` stays 0 and the previously captured values stay unchanged.
- R7: A fourth payload byte is NACKed and the message is discarded, so the following stop raises no interrupt.
- R8: If a message completes while `notify_irq` is 1 and no clear arrives in the same cycle, `notify_ovr` goes to 1 and `notify_dev` and `notify_word` keep the first message's values.
- R9: A pulse on `irq_clear` drops `notify_irq` and `notify_ovr` in the next cycle. If a clear and a completing stop arrive in the same cycle, the new message is captured, `notify_irq` is 1 and `notify_ovr` is 0.
- R10: Each of the three payload bytes of an accepted message is ACKed, with `resp_valid` and `resp_ack` both 1 the cycle after the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated-start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| addr_valid | input | 1 | Address byte received |
| addr_byte | input | 8 | Address in [7:1], direction in [0] |
| rx_valid | input | 1 | Data byte received |
| rx_byte | input | 8 | Received data byte |
| irq_clear | input | 1 | Software clear of the interrupt and overrun flag |
| resp_valid | output | 1 | An ACK/NACK decision is present |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| notify_irq | output | 1 | Sticky interrupt for a captured message |
| notify_ovr | output | 1 | A message arrived while the interrupt was pending |
| notify_dev | output | 7 | Captured device address |
| notify_word | output | 16 | Captured data word {high, low} |

## Verification
The bench builds the block with its default 7-bit address, 8-bit bytes and host address 0x08. That configuration is small enough to sweep every one of the 256 address-and-direction combinations and every one of the 256 values of the device byte. For each device byte, the two data bytes are derived from it arithmetically, so the low-bit drop and the byte ordering are checked across the full byte range. Directed sequences then cover every truncation point, the surplus fourth payload byte, overrun, and a clear that lands in the same cycle as a completing stop.

// File: rtl/smb_notify_pkg.sv
package smb_notify_pkg;

  // Position of the message parser within a Host Notify frame
  typedef enum logic [2:0] {
    NS_IDLE,   // no frame of interest open
    NS_ADDR,   // start seen, waiting for the address byte
    NS_DEV,    // waiting for the device-address payload byte
    NS_LO,     // waiting for the low data byte
    NS_HI,     // waiting for the high data byte
    NS_END     // all payload received, waiting for stop
  } nfy_state_t;

  localparam logic DIR_WRITE = 1'b0;

endpackage

// File: rtl/smb_notify_fsm.sv
module smb_notify_fsm
  import smb_notify_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08,
  localparam int WORD_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_addr,
  input  logic [BYTE_W-1:0] addr_in,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic              commit,
  output logic [ADDR_W-1:0] stg_dev,
  output logic [WORD_W-1:0] stg_word
);

  nfy_state_t         state;
  logic [BYTE_W-1:0]  stg_lo;
  logic [BYTE_W-1:0]  stg_hi;
  logic               host_hit;

  assign host_hit = (addr_in[BYTE_W-1 -: ADDR_W] == HOST_ADDR) && (addr_in[0] == DIR_WRITE);
  assign commit   = (state == NS_END) && ev_stop && !ev_start;
  assign stg_word = {stg_hi, stg_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= NS_IDLE;
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      stg_dev    <= '0;
      stg_lo     <= '0;
      stg_hi     <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      if (ev_start) begin
        state <= NS_ADDR;
      end else if (ev_stop) begin
        state <= NS_IDLE;
      end else if (ev_addr) begin
        resp_valid <= 1'b1;
        if (state == NS_ADDR && host_hit) begin
          resp_ack <= 1'b1;
          state    <= NS_DEV;
        end else begin
          state    <= NS_IDLE;
        end
      end else if (ev_byte) begin
        resp_valid <= 1'b1;
        case (state)
          NS_DEV: begin
            resp_ack <= 1'b1;
            stg_dev  <= byte_in[BYTE_W-1 -: ADDR_W];
            state    <= NS_LO;
          end
          NS_LO: begin
            resp_ack <= 1'b1;
            stg_lo   <= byte_in;
            state    <= NS_HI;
          end
          NS_HI: begin
            resp_ack <= 1'b1;
            stg_hi   <= byte_in;
            state    <= NS_END;
          end
          default: state <= NS_IDLE;
        endcase
      end
    end
  end

  // R2 / R10: a decision only ever answers an address or data byte
  assert_resp_follows_event_R2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(ev_addr || ev_byte));

  // R10: an ACK is only ever given with a valid decision
  assert_ack_has_valid_R10: assert property (@(posedge clk) disable iff (rst)
    resp_ack |-> resp_valid);

endmodule

// File: rtl/smb_notify_capture.sv
module smb_notify_capture #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              clr,
  input  logic [ADDR_W-1:0] in_dev,
  input  logic [WORD_W-1:0] in_word,
  output logic              irq,
  output logic              ovr,
  output logic [ADDR_W-1:0] dev,
  output logic [WORD_W-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      ovr  <= 1'b0;
      dev  <= '0;
      word <= '0;
    end else if (commit && (!irq || clr)) begin
      irq  <= 1'b1;
      ovr  <= 1'b0;
      dev  <= in_dev;
      word <= in_word;
    end else if (commit) begin
      ovr  <= 1'b1;
    end else if (clr) begin
      irq  <= 1'b0;
      ovr  <= 1'b0;
    end
  end

  assert_irq_rise_needs_commit_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(commit));

  assert_ovr_implies_irq_R8: assert property (@(posedge clk) disable iff (rst)
    ovr |-> irq);

  assert_pending_values_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> ($stable(dev) && $stable(word)));

  assert_clear_drops_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !commit) |=> (!irq && !ovr));

endmodule

// File: rtl/smb_notify_rx.sv
module smb_notify_rx #(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_valid,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              irq_clear,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic              notify_irq,
  output logic              notify_ovr,
  output logic [ADDR_W-1:0] notify_dev,
  output logic [WORD_W-1:0] notify_word
);

  logic              commit;
  logic [ADDR_W-1:0] stg_dev;
  logic [WORD_W-1:0] stg_word;

  smb_notify_fsm #(
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W),
    .HOST_ADDR (HOST_ADDR)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ev_start   (bus_start),
    .ev_stop    (bus_stop),
    .ev_addr    (addr_valid),
    .addr_in    (addr_byte),
    .ev_byte    (rx_valid),
    .byte_in    (rx_byte),
    .resp_valid (resp_valid),
    .resp_ack   (resp_ack),
    .commit     (commit),
    .stg_dev    (stg_dev),
    .stg_word   (stg_word)
  );

  smb_notify_capture #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .clr     (irq_clear),
    .in_dev  (stg_dev),
    .in_word (stg_word),
    .irq     (notify_irq),
    .ovr     (notify_ovr),
    .dev     (notify_dev),
    .word    (notify_word)
  );

endmodule

// File: tb/tb_smb_notify_rx.sv
`timescale 1ns/1ps
module tb_smb_notify_rx;

  localparam logic [6:0] HOST = 7'h08;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_start = 1'b0, bus_stop = 1'b0, addr_valid = 1'b0, rx_valid = 1'b0, irq_clear = 1'b0;
  logic [7:0]  addr_byte = '0, rx_byte = '0;
  logic        resp_valid, resp_ack, notify_irq, notify_ovr;
  logic [6:0]  notify_dev;
  logic [15:0] notify_word;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  smb_notify_rx dut (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .irq_clear(irq_clear), .resp_valid(resp_valid), .resp_ack(resp_ack),
    .notify_irq(notify_irq), .notify_ovr(notify_ovr),
    .notify_dev(notify_dev), .notify_word(notify_word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  task automatic do_addr(input logic [6:0] a, input logic dir);
    @(negedge clk); addr_byte = {a, dir}; addr_valid = 1'b1;
    @(negedge clk); addr_valid = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // Full accepted message up to (not including) the stop
  task automatic send_payload(input logic [7:0] d, input logic [7:0] lo, input logic [7:0] hi);
    do_start();
    do_addr(HOST, 1'b0);
    do_byte(d);
    do_byte(lo);
    do_byte(hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [6:0]  kdev;
    logic [15:0] kword;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!notify_irq && !notify_ovr && !resp_valid && !resp_ack, "R1 flags", {notify_irq, notify_ovr, resp_valid, resp_ack}, 0);
    chk(notify_dev == 0 && notify_word == 0, "R1 values", {notify_dev, notify_word}, 0);

    // R2 sweep of every address and direction
    for (int a = 0; a < 128; a++) begin
      for (int r = 0; r < 2; r++) begin
        bit exp_ack;
        exp_ack = (a == HOST) && (r == 0);
        do_start();
        do_addr(a[6:0], r[0]);
        chk(resp_valid && resp_ack == exp_ack, "R2 address decision", {resp_valid, resp_ack}, {1'b1, exp_ack});
        if (!exp_ack && a[1:0] == 2'b00) begin
          do_byte(a[7:0]);
          chk(resp_valid && !resp_ack, "R2 byte after NACKed address", {resp_valid, resp_ack}, 2'b10);
        end
        do_stop();
        chk(!notify_irq, "R2 no interrupt on rejected or empty frame", notify_irq, 0);
      end
    end

    // R3 R4 R5 R9 R10 sweep of every device byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] lo, hi;
      lo = b[7:0] ^ 8'h5A;
      hi = ~b[7:0] + 8'd3;
      do_start();
      do_addr(HOST, 1'b0);
      do_byte(b[7:0]);
      chk(resp_valid && resp_ack, "R10 device byte ACK", {resp_valid, resp_ack}, 2'b11);
      do_byte(lo);
      chk(resp_valid && resp_ack, "R10 low byte ACK", {resp_valid, resp_ack}, 2'b11);
      do_byte(hi);
      chk(resp_valid && resp_ack, "R10 high byte ACK", {resp_valid, resp_ack}, 2'b11);
      chk(!notify_irq, "R5 no interrupt before stop", notify_irq, 0);
      do_stop();
      chk(notify_irq && !notify_ovr, "R5 interrupt after stop", {notify_irq, notify_ovr}, 2'b10);
      chk(notify_dev == b[7:1], "R3 device address", notify_dev, b[7:1]);
      chk(notify_word == {hi, lo}, "R4 word order", notify_word, {hi, lo});
      do_clear();
      chk(!notify_irq && !notify_ovr, "R9 clear", {notify_irq, notify_ovr}, 0);
    end
    kdev  = 7'h7F;
    kword = {8'd3, 8'hA5};

    // R6 truncation by stop or restart at each point
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 2; e++) begin
        do_start();
        do_addr(HOST, 1'b0);
        if (k > 0) do_byte(8'h22);
        if (k > 1) do_byte(8'h33);
        if (k > 2) do_byte(8'h44);
        if (e == 0 && k < 3) do_stop();
        else begin
          do_start();
          do_stop();
        end
        chk(!notify_irq, "R6 truncated frame discarded", notify_irq, 0);
        chk(notify_dev == kdev && notify_word == kword, "R6 values unchanged", {notify_dev, notify_word}, {kdev, kword});
      end
    end

    // R7 surplus fourth payload byte
    send_payload(8'h10, 8'h11, 8'h12);
    do_byte(8'h13);
    chk(resp_valid && !resp_ack, "R7 fourth byte NACK", {resp_valid, resp_ack}, 2'b10);
    do_stop();
    chk(!notify_irq, "R7 no interrupt", notify_irq, 0);

    // R8 overrun keeps first values
    send_payload(8'h40, 8'hC1, 8'hC2);
    do_stop();
    send_payload(8'h60, 8'hD1, 8'hD2);
    do_stop();
    chk(notify_irq && notify_ovr, "R8 overrun flag", {notify_irq, notify_ovr}, 2'b11);
    chk(notify_dev == 7'h20 && notify_word == 16'hC2C1, "R8 first values kept", {notify_dev, notify_word}, {7'h20, 16'hC2C1});
    do_clear();
    chk(!notify_irq && !notify_ovr, "R9 clear after overrun", {notify_irq, notify_ovr}, 0);

    // R9 clear in the same cycle as a completing stop
    send_payload(8'h40, 8'hC1, 8'hC2);
    do_stop();
    send_payload(8'h9B, 8'hE1, 8'hE2);
    @(negedge clk); bus_stop = 1'b1; irq_clear = 1'b1;
    @(negedge clk); bus_stop = 1'b0; irq_clear = 1'b0;
    chk(notify_irq && !notify_ovr, "R9 simultaneous clear and commit flags", {notify_irq, notify_ovr}, 2'b10);
    chk(notify_dev == 7'h4D && notify_word == 16'hE2E1, "R9 new values captured", {notify_dev, notify_word}, {7'h4D, 16'hE2E1});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule